// File: doc/BRIEF.md
# Rate-1/3 Parallel Concatenated Convolutional Encoder

This block turns a block of `BLK_LEN` information bits into a rate-1/3 turbo code stream. Two identical recursive systematic convolutional encoders with three delay stages (eight states) run side by side. The first one consumes the information bits in their arrival order. The second one consumes the same block read back in a permuted order. For every step the block emits one triple: the systematic bit, the parity of the first encoder and the parity of the second encoder. After the information steps both encoders are driven back to the all-zero state by three termination steps, and the block emits those tail bits as well.

The incoming bits are collected in an internal buffer of `BLK_LEN` positions, so that the second encoder can read them out of order. The permutation comes from one of two sources, chosen by a parameter. It can come from an external lookup: the block presents a position and receives the permuted index one clock later. It can also come from an internal affine address generator. Both the input and the output use a valid/ready handshake. While a block is being encoded the input is held off, and a stalled output keeps its triple unchanged.

Top module: `pcc_turbo_encoder`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: For the information steps 0..BLK_LEN-1, `out_sys` equals the buffered bit at that position. Position 0 is the bit accepted with `in_first`, or the first bit accepted after reset or after the previous block.
- R3: `out_par1` is the parity of a recursive encoder that starts each block in the all-zero state. Its feedback polynomial is 1+D+D^3 (octal 15) and its parity polynomial is 1+D^2+D^3 (octal 13). Its input is the information bits in natural order.
- R4: `out_par2` is produced by the same code, starting from zero each block, applied to the permuted sequence. For step i, `perm_pos` shows i, and the encoder uses the buffered bit at the position given by `perm_idx` on the following cycle.
- R5: Each block yields BLK_LEN+3 triples. The last three carry `out_tail`=1. In those steps each encoder takes its own feedback bit as input: `out_sys` carries encoder 1's tail bit, `out_tail2` carries encoder 2's tail bit, and both encoders end in state zero. During information steps `out_tail` and `out_tail2` are 0.
- R6: `out_first` is 1 only on step 0. `out_last` is 1 only on the final tail step.
- R7: `in_ready` is 0 from the acceptance of a block's last bit until its final triple is taken. An input bit offered during that time is not lost: it is taken afterwards as bit 0 of the next block.
- R8: While `out_valid` is 1 and `out_ready` is 0, every output field stays unchanged. Every triple of a block is delivered exactly once.
- R9: A bit accepted with `in_last` closes the block early. The positions not written are encoded as 0.
- R10: A bit accepted with `in_first` in the middle of filling discards the bits gathered so far and becomes position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Block is filling and accepts a bit |
| in_bit | input | 1 | Information bit |
| in_first | input | 1 | Bit is position 0 of a new block |
| in_last | input | 1 | Bit is the final bit of the block |
| perm_pos | output | IDX_W | Natural position whose permuted index is requested |
| perm_idx | input | IDX_W | Permuted index, one cycle after `perm_pos` |
| out_valid | output | 1 | Triple available |
| out_ready | input | 1 | Consumer takes the triple |
| out_sys | output | 1 | Systematic bit, or encoder 1 tail bit |
| out_par1 | output | 1 | Parity of encoder 1 |
| out_par2 | output | 1 | Parity of encoder 2 |
| out_tail | output | 1 | Triple is a termination step |
| out_tail2 | output | 1 | Encoder 2 tail bit (0 on information steps) |
| out_first | output | 1 | First triple of a block |
| out_last | output | 1 | Final triple of a block |

## Verification
The bench goes after the seams of the encoder.

- Termination steps: a design that fed the tail steps with the information input instead of the feedback bit would leave a non-zero state and emit wrong tail parities.
- Permutation latency: a design that sampled `perm_idx` one cycle early would read an index that belongs to another position, which shows up as a wrong `out_par2`.
- Block boundaries: an early end of block and a restart in the middle of filling are both exercised. A design that did not clear stale buffer positions would encode bits left over from the previous block.
- Back-pressure: with a toggling `out_ready` and a bit offered during encoding, a design that dropped or repeated a triple, or swallowed the offered bit, would break the expected sequence.

// File: rtl/pcc_turbo_pkg.sv
package pcc_turbo_pkg;

   typedef enum logic [1:0] {
      PH_FILL = 2'd0,
      PH_LOOK = 2'd1,
      PH_CAPT = 2'd2,
      PH_HOLD = 2'd3
   } enc_phase_t;

   typedef struct packed {
      logic first;
      logic last;
      logic tail;
      logic sys;
      logic par1;
      logic par2;
      logic tail2;
   } enc_triple_t;

   function automatic int gcd_f(input int a, input int b);
      int x;
      int y;
      int t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

endpackage

// File: rtl/pcc_bit_buffer.sv
module pcc_bit_buffer #(
   parameter int DEPTH = 40,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic          wbit,
   input  logic [AW-1:0] raddr_a,
   output logic          rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic          rdata_b
);

   logic [DEPTH-1:0] mem_q;
   logic [DEPTH-1:0] mem_d;

   always_comb begin
      mem_d = clr ? '0 : mem_q;
      for (int i = 0; i < DEPTH; i++) begin
         if (we && (int'(waddr) == i)) mem_d[i] = wbit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q <= '0;
      else        mem_q <= mem_d;
   end

   always_comb begin
      rdata_a = 1'b0;
      rdata_b = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (int'(raddr_a) == i) rdata_a = mem_q[i];
         if (int'(raddr_b) == i) rdata_b = mem_q[i];
      end
   end

   // R9
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/pcc_rsc_encoder.sv
module pcc_rsc_encoder #(
   parameter int          MEM     = 3,
   parameter logic [MEM:0] FB_POLY  = 4'b1101,
   parameter logic [MEM:0] FWD_POLY = 4'b1011
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           adv,
   input  logic           term,
   input  logic           u_in,
   output logic           sys_o,
   output logic           par_o,
   output logic [MEM-1:0] state_o
);

   // st_q[k-1] holds the value delayed by k steps
   logic [MEM-1:0] st_q;
   logic [MEM-1:0] fb_taps;
   logic [MEM-1:0] fw_taps;
   logic           fbk;
   logic           a_bit;

   for (genvar k = 1; k <= MEM; k++) begin : g_taps
      assign fb_taps[k-1] = FB_POLY[MEM-k];
      assign fw_taps[k-1] = FWD_POLY[MEM-k];
   end

   if (FB_POLY[MEM] != 1'b1) begin : g_bad_fb
      $error("feedback polynomial needs a unit constant term");
   end

   assign fbk   = ^(fb_taps & st_q);
   assign sys_o = term ? fbk : u_in;
   assign a_bit = sys_o ^ fbk;
   assign par_o = (FWD_POLY[MEM] & a_bit) ^ (^(fw_taps & st_q));
   assign state_o = st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= '0;
      else if (clr) st_q <= '0;
      else if (adv) st_q <= {st_q[MEM-2:0], a_bit};
   end

   // R5
   term_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && term && !clr) |=> (st_q[0] == 1'b0));

endmodule

// File: rtl/pcc_perm_source.sv
module pcc_perm_source #(
   parameter int BLK_LEN  = 40,
   parameter bit USE_GEN  = 1'b0,
   parameter int GEN_MUL  = 7,
   parameter int GEN_OFF  = 3,
   parameter int IDX_W    = $clog2(BLK_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             adv,
   input  logic [IDX_W-1:0] ext_idx,
   output logic [IDX_W-1:0] idx_o
);

   if (USE_GEN) begin : g_gen
      localparam logic [IDX_W:0] MUL_W = (IDX_W+1)'(GEN_MUL);
      localparam logic [IDX_W:0] LEN_W = (IDX_W+1)'(BLK_LEN);
      logic [IDX_W-1:0] idx_q;
      logic [IDX_W:0]   sum;

      if (GEN_MUL < 1 || GEN_MUL >= BLK_LEN || GEN_OFF < 0 || GEN_OFF >= BLK_LEN)
      begin : g_bad_rng
         $error("generator step or offset out of range");
      end
      if (pcc_turbo_pkg::gcd_f(GEN_MUL, BLK_LEN) != 1) begin : g_bad_gcd
         $error("generator step must be coprime to block length");
      end

      assign sum = {1'b0, idx_q} + MUL_W;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     idx_q <= IDX_W'(GEN_OFF);
         else if (start) idx_q <= IDX_W'(GEN_OFF);
         else if (adv)   idx_q <= (sum >= LEN_W) ? IDX_W'(sum - LEN_W) : IDX_W'(sum);
      end

      assign idx_o = idx_q;
      logic unused_ext;
      assign unused_ext = ^ext_idx;
   end else begin : g_ext
      assign idx_o = ext_idx;
      logic unused_ctl;
      assign unused_ctl = start ^ adv;
   end

   // R4
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> (int'(idx_o) < BLK_LEN));

endmodule

// File: rtl/pcc_turbo_encoder.sv
module pcc_turbo_encoder
   import pcc_turbo_pkg::*;
#(
   parameter int BLK_LEN  = 40,
   parameter bit USE_GEN  = 1'b0,
   parameter int GEN_MUL  = 7,
   parameter int GEN_OFF  = 3,
   parameter int IDX_W    = $clog2(BLK_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             in_bit,
   input  logic             in_first,
   input  logic             in_last,
   output logic [IDX_W-1:0] perm_pos,
   input  logic [IDX_W-1:0] perm_idx,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             out_sys,
   output logic             out_par1,
   output logic             out_par2,
   output logic             out_tail,
   output logic             out_tail2,
   output logic             out_first,
   output logic             out_last
);

   localparam int MEM    = 3;
   localparam int NSTEP  = BLK_LEN + MEM;
   localparam int STEP_W = $clog2(NSTEP + 1);
   localparam logic [STEP_W-1:0] INFO_END  = STEP_W'(BLK_LEN);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEP - 1);
   localparam logic [IDX_W-1:0]  LAST_POS  = IDX_W'(BLK_LEN - 1);

   if (BLK_LEN < 2 || IDX_W < $clog2(BLK_LEN)) begin : g_bad_len
      $error("block length or index width invalid");
   end

   enc_phase_t       phase_q;
   logic [STEP_W-1:0] step_q;
   logic [IDX_W-1:0]  wptr_q;
   enc_triple_t      out_q;

   logic             take_in;
   logic [IDX_W-1:0] wpos;
   logic             close_blk;
   logic             info_step;
   logic             hand_out;
   logic             end_blk;
   logic             rd_nat;
   logic             rd_perm;
   logic [IDX_W-1:0] pidx;
   logic             sys1;
   logic             sys2;
   logic             par1;
   logic             par2;
   logic [MEM-1:0]   st1;
   logic [MEM-1:0]   st2;

   assign in_ready  = (phase_q == PH_FILL);
   assign out_valid = (phase_q == PH_HOLD);
   assign take_in   = in_ready && in_valid;
   assign wpos      = in_first ? '0 : wptr_q;
   assign close_blk = take_in && (in_last || (wpos == LAST_POS));
   assign info_step = (step_q < INFO_END);
   assign hand_out  = out_valid && out_ready;
   assign end_blk   = hand_out && (step_q == LAST_STEP);
   assign perm_pos  = info_step ? step_q[IDX_W-1:0] : '0;

   pcc_bit_buffer #(.DEPTH(BLK_LEN), .AW(IDX_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     ((take_in && in_first) || end_blk),
      .we      (take_in),
      .waddr   (wpos),
      .wbit    (in_bit),
      .raddr_a (perm_pos),
      .rdata_a (rd_nat),
      .raddr_b (pidx),
      .rdata_b (rd_perm)
   );

   pcc_perm_source #(
      .BLK_LEN (BLK_LEN), .USE_GEN (USE_GEN), .GEN_MUL (GEN_MUL),
      .GEN_OFF (GEN_OFF), .IDX_W (IDX_W)
   ) u_perm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (close_blk),
      .adv     (hand_out && info_step),
      .ext_idx (perm_idx),
      .idx_o   (pidx)
   );

   pcc_rsc_encoder #(.MEM(MEM)) u_enc1 (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (end_blk),
      .adv     (phase_q == PH_CAPT),
      .term    (!info_step),
      .u_in    (rd_nat),
      .sys_o   (sys1),
      .par_o   (par1),
      .state_o (st1)
   );

   pcc_rsc_encoder #(.MEM(MEM)) u_enc2 (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (end_blk),
      .adv     (phase_q == PH_CAPT),
      .term    (!info_step),
      .u_in    (rd_perm),
      .sys_o   (sys2),
      .par_o   (par2),
      .state_o (st2)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_FILL;
         step_q  <= '0;
         wptr_q  <= '0;
         out_q   <= '0;
      end else begin
         case (phase_q)
            PH_FILL: begin
               if (take_in) begin
                  wptr_q <= wpos + IDX_W'(1);
                  if (close_blk) begin
                     wptr_q  <= '0;
                     step_q  <= '0;
                     phase_q <= PH_LOOK;
                  end
               end
            end
            PH_LOOK: phase_q <= PH_CAPT;
            PH_CAPT: begin
               out_q.first <= (step_q == '0);
               out_q.last  <= (step_q == LAST_STEP);
               out_q.tail  <= !info_step;
               out_q.sys   <= sys1;
               out_q.par1  <= par1;
               out_q.par2  <= par2;
               out_q.tail2 <= info_step ? 1'b0 : sys2;
               phase_q     <= PH_HOLD;
            end
            default: begin
               if (hand_out) begin
                  if (step_q == LAST_STEP) begin
                     phase_q <= PH_FILL;
                  end else begin
                     step_q  <= step_q + STEP_W'(1);
                     phase_q <= PH_LOOK;
                  end
               end
            end
         endcase
      end
   end

   assign out_sys   = out_q.sys;
   assign out_par1  = out_q.par1;
   assign out_par2  = out_q.par2;
   assign out_tail  = out_q.tail;
   assign out_tail2 = out_q.tail2;
   assign out_first = out_q.first;
   assign out_last  = out_q.last;

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_q)));

   // R5
   tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> ((st1 == '0) && (st2 == '0)));

   // R6
   mark_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_first && out_last));

   // R7
   no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      close_blk |=> !in_ready);

endmodule

// File: tb/test_pcc_turbo_encoder.sv
module test_pcc_turbo_encoder;

   localparam int K    = 16;
   localparam int IW   = 4;
   localparam int NB   = K + 3;
   localparam int MAXE = 12 * NB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic          in_bit = 1'b0;
   logic          in_first = 1'b0;
   logic          in_last = 1'b0;
   logic [IW-1:0] perm_pos;
   logic [IW-1:0] perm_idx = '0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic          out_sys, out_par1, out_par2, out_tail, out_tail2, out_first, out_last;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int ew    = 0;
   int oidx  = 0;
   int rmode = 0;
   logic [6:0] exp_rec [MAXE];
   logic       mon_r;
   logic       held = 1'b0;
   logic [6:0] held_rec = '0;
   logic [6:0] cur;

   always #5 clk = ~clk;

   pcc_turbo_encoder #(.BLK_LEN(K)) i_pcc_turbo_encoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_bit(in_bit), .in_first(in_first), .in_last(in_last),
      .perm_pos(perm_pos), .perm_idx(perm_idx), .out_valid(out_valid),
      .out_ready(out_ready), .out_sys(out_sys), .out_par1(out_par1),
      .out_par2(out_par2), .out_tail(out_tail), .out_tail2(out_tail2),
      .out_first(out_first), .out_last(out_last)
   );

   function automatic logic [IW-1:0] pi_f(input logic [IW-1:0] p);
      return IW'((5 * int'(p) + 3) % K);
   endfunction

   // lookup with one cycle of latency
   always @(posedge clk) perm_idx <= pi_f(perm_pos);

   task automatic chk(input logic ok, input string tag, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (out #%0d)", tag, act, expv, oidx);
      end
   endtask

   // independent model: feedback 1+D+D^3, parity 1+D^2+D^3
   task automatic add_block(input logic [K-1:0] bits);
      logic [2:0] s1, s2;
      logic fb1, fb2, a1, a2, u1, u2, p1, p2;
      s1 = '0; s2 = '0;
      for (int i = 0; i < NB; i++) begin
         fb1 = s1[0] ^ s1[2];
         fb2 = s2[0] ^ s2[2];
         if (i < K) begin
            u1 = bits[i];
            u2 = bits[pi_f(IW'(i))];
         end else begin
            u1 = fb1;
            u2 = fb2;
         end
         a1 = u1 ^ fb1;
         a2 = u2 ^ fb2;
         p1 = a1 ^ s1[1] ^ s1[2];
         p2 = a2 ^ s2[1] ^ s2[2];
         s1 = {s1[1:0], a1};
         s2 = {s2[1:0], a2};
         exp_rec[ew] = {(i == 0), (i == NB-1), (i >= K), u1, p1, p2, (i >= K) ? u2 : 1'b0};
         ew++;
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      mon_r = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
      out_ready = mon_r;
      cur = {out_first, out_last, out_tail, out_sys, out_par1, out_par2, out_tail2};
      if (rst_n && held && out_valid)
         chk(cur == held_rec, "R8 stalled triple changed", int'(cur), int'(held_rec));
      if (rst_n && out_valid && mon_r) begin
         if (oidx >= ew) begin
            chk(1'b0, "R8 unexpected extra triple", oidx, ew);
         end else begin
            chk(out_sys  == exp_rec[oidx][3], "R2 R5 out_sys",   out_sys,   exp_rec[oidx][3]);
            chk(out_par1 == exp_rec[oidx][2], "R3 out_par1",     out_par1,  exp_rec[oidx][2]);
            chk(out_par2 == exp_rec[oidx][1], "R4 out_par2",     out_par2,  exp_rec[oidx][1]);
            chk(out_tail == exp_rec[oidx][4], "R5 out_tail",     out_tail,  exp_rec[oidx][4]);
            chk(out_tail2 == exp_rec[oidx][0], "R5 out_tail2",   out_tail2, exp_rec[oidx][0]);
            chk(out_first == exp_rec[oidx][6], "R6 out_first",   out_first, exp_rec[oidx][6]);
            chk(out_last == exp_rec[oidx][5], "R6 out_last",     out_last,  exp_rec[oidx][5]);
         end
         oidx++;
      end
      held = rst_n && out_valid && !mon_r;
      held_rec = cur;
   end

   always @(posedge clk) begin
      if (cyc > 100000) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", oidx, ew);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic send_bit(input logic b, input logic f, input logic l, input logic gap);
      in_valid = 1'b1; in_bit = b; in_first = f; in_last = l;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (gap) begin
         in_valid = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic send_block(input logic [K-1:0] bits, input logic gap);
      for (int i = 0; i < K; i++) send_bit(bits[i], (i == 0), (i == K-1), gap);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
   endtask

   task automatic drain();
      while (oidx < ew) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
      chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
   endtask

   task automatic t_plain();
      logic [K-1:0] b = 16'b1011_0010_1110_0101;
      rmode = 0;
      add_block(b);
      send_block(b, 1'b0);
      drain();
   endtask

   task automatic t_stall();
      logic [K-1:0] b = '1;
      rmode = 1;
      add_block(b);
      send_block(b, 1'b1);
      drain();
   endtask

   task automatic t_back_to_back();
      logic [K-1:0] a = 16'b0110_1001_0001_1101;
      logic [K-1:0] b = 16'b1000_0000_0000_0001;
      rmode = 1;
      add_block(a);
      add_block(b);
      send_block(a, 1'b0);
      // R7: input held off while the block is encoded
      chk(in_ready == 1'b0, "R7 in_ready during encode", in_ready, 0);
      repeat (5) @(negedge clk);
      chk(in_ready == 1'b0, "R7 in_ready later in encode", in_ready, 0);
      send_block(b, 1'b0);
      drain();
   endtask

   task automatic t_early_end();
      logic [K-1:0] b = '0;
      rmode = 0;
      b[4:0] = 5'b11011;
      add_block(b);
      for (int i = 0; i < 5; i++) send_bit(b[i], (i == 0), (i == 4), 1'b0);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
      // R9: block closes after the marked bit
      chk(in_ready == 1'b0, "R9 block closed by in_last", in_ready, 0);
      drain();
   endtask

   task automatic t_restart();
      logic [K-1:0] b = 16'b0101_1100_0011_1010;
      rmode = 0;
      // R10: partial fill of ones, then a restart with in_first
      for (int i = 0; i < 4; i++) send_bit(1'b1, (i == 0), 1'b0, 1'b0);
      add_block(b);
      send_block(b, 1'b0);
      drain();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_stall();
      t_back_to_back();
      t_early_end();
      t_restart();
      // R8: every triple delivered once
      chk(oidx == ew, "R8 triple count", oidx, ew);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule